// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the purely combinational control for a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, writeback). It looks at the source and destination register numbers, the write-enable flags and the load flags held in the decode, execute, memory and writeback pipeline registers. From these it selects the bypass sources for the two execute-stage ALU operands and for the two operands of the equality comparator that sits in decode.

Branches are resolved in decode and assumed not taken. A taken branch or a jump discards the one instruction fetched behind it. A dependency that no bypass can cover holds the PC and the fetch/decode register, and sends an empty slot into execute. These cases are a load followed at once by its consumer, and a branch whose operand is still being computed. The register file writes early in the cycle and reads late, so a writeback-stage result needs no path into decode.

Top module: `hzd_unit`

## Requirements
- R1: An execute operand select is 2'b10 (take the EX/MEM result) when the memory-stage instruction writes a nonzero register equal to that operand's source.
- R2: An execute operand select is 2'b01 (take the MEM/WB result) when only the writeback-stage instruction writes a nonzero matching register. It is 2'b00 (register file) when neither stage matches. The code 2'b11 never appears.
- R3: When both the memory and the writeback stage match an execute operand, the select is 2'b10.
- R4: A producer whose destination is register 0, or whose write flag is clear, causes no bypass and no stall.
- R5: A load in execute whose nonzero destination equals either decode source register raises hold_fetch and bubble_ex, both 1, for that cycle.
- R6: A branch in decode whose source equals the nonzero destination of a writing non-load in execute stalls for that cycle.
- R7: A branch in decode whose source equals the nonzero destination of a load in the memory stage stalls for that cycle. A load feeding a branch directly therefore costs two stall cycles, and the third cycle has no stall.
- R8: A decode comparator select is 2'b10 when a writing non-load in the memory stage has a matching nonzero destination, and 2'b00 otherwise. A load in memory and any writeback-stage match both give 2'b00.
- R9: flush_fd is 1 for a jump in decode, or for a branch in decode with br_equal set, when there is no stall.
- R10: A stall blocks the flush in the same cycle, even for a jump or a taken branch.
- R11: With no dependency, hold_fetch and bubble_ex are 0, and a branch whose comparison is false does not flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | 5 | Decode first source register |
| id_rt | input | 5 | Decode second source register |
| id_beq | input | 1 | Decode holds a conditional branch |
| id_jump | input | 1 | Decode holds a jump |
| br_equal | input | 1 | Comparator result for the branch in decode |
| ex_rs | input | 5 | Execute first source register |
| ex_rt | input | 5 | Execute second source register |
| ex_rd | input | 5 | Execute destination register |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_ld | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_ld | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Writeback destination register |
| wb_we | input | 1 | Writeback instruction writes a register |
| fwd_ex_a | output | 2 | Execute operand A source select |
| fwd_ex_b | output | 2 | Execute operand B source select |
| fwd_id_a | output | 2 | Decode comparator operand A select |
| fwd_id_b | output | 2 | Decode comparator operand B select |
| hold_fetch | output | 1 | Hold the PC and the fetch/decode register |
| bubble_ex | output | 1 | Load an empty slot into the decode/execute register |
| flush_fd | output | 1 | Discard the fetch/decode register |

## Verification
The bench aims at the points where the rules meet. It sets up a double match on one operand, where a design with the priority reversed would hand the older writeback value to execute. It uses register 0 as destination, where a careless compare would bypass or stall on the hard-wired zero. It steps a load into a branch over three cycles, where a design missing the memory-stage check would let the branch compare stale data after one stall. It also drives a stalled taken branch, where a design without the stall gate would throw away the correct fall-through instruction before the comparison is valid.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    localparam int REG_AW = 5;

    typedef logic [REG_AW-1:0] reg_id_t;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } byp_e;

    typedef struct packed {
        reg_id_t dst;
        logic    wr;
        logic    ld;
    } prod_t;

    function automatic logic dep_hit(reg_id_t src, reg_id_t dst, logic wr);
        return wr && (dst != '0) && (dst == src);
    endfunction
endpackage

// File: rtl/hzd_ex_bypass.sv
module hzd_ex_bypass
    import hzd_pkg::*;
(
    input  reg_id_t src,
    input  reg_id_t mem_dst,
    input  logic    mem_wr,
    input  reg_id_t wb_dst,
    input  logic    wb_wr,
    output byp_e    sel
);
    always_comb begin
        if (dep_hit(src, mem_dst, mem_wr))
            sel = SRC_MEM;
        else if (dep_hit(src, wb_dst, wb_wr))
            sel = SRC_WB;
        else
            sel = SRC_RF;
    end
endmodule

// File: rtl/hzd_id_bypass.sv
module hzd_id_bypass
    import hzd_pkg::*;
(
    input  reg_id_t src,
    input  prod_t   mem_p,
    output byp_e    sel
);
    // a load's data is not ready in the memory stage; the stall logic covers it
    always_comb begin
        if (!mem_p.ld && dep_hit(src, mem_p.dst, mem_p.wr))
            sel = SRC_MEM;
        else
            sel = SRC_RF;
    end
endmodule

// File: rtl/hzd_stall.sv
module hzd_stall
    import hzd_pkg::*;
(
    input  reg_id_t id_rs,
    input  reg_id_t id_rt,
    input  logic    id_beq,
    input  prod_t   ex_p,
    input  prod_t   mem_p,
    output logic    stall
);
    logic ex_dep, mem_dep, load_use, br_on_ex, br_on_mem;

    always_comb begin
        ex_dep    = dep_hit(id_rs, ex_p.dst, ex_p.wr)  || dep_hit(id_rt, ex_p.dst, ex_p.wr);
        mem_dep   = dep_hit(id_rs, mem_p.dst, mem_p.wr) || dep_hit(id_rt, mem_p.dst, mem_p.wr);
        load_use  = ex_p.ld && ex_dep;
        br_on_ex  = id_beq && ex_dep;
        br_on_mem = id_beq && mem_p.ld && mem_dep;
        stall     = load_use || br_on_ex || br_on_mem;
    end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
(
    input  logic [hzd_pkg::REG_AW-1:0] id_rs,
    input  logic [hzd_pkg::REG_AW-1:0] id_rt,
    input  logic                       id_beq,
    input  logic                       id_jump,
    input  logic                       br_equal,
    input  logic [hzd_pkg::REG_AW-1:0] ex_rs,
    input  logic [hzd_pkg::REG_AW-1:0] ex_rt,
    input  logic [hzd_pkg::REG_AW-1:0] ex_rd,
    input  logic                       ex_we,
    input  logic                       ex_ld,
    input  logic [hzd_pkg::REG_AW-1:0] mem_rd,
    input  logic                       mem_we,
    input  logic                       mem_ld,
    input  logic [hzd_pkg::REG_AW-1:0] wb_rd,
    input  logic                       wb_we,
    output logic [1:0]                 fwd_ex_a,
    output logic [1:0]                 fwd_ex_b,
    output logic [1:0]                 fwd_id_a,
    output logic [1:0]                 fwd_id_b,
    output logic                       hold_fetch,
    output logic                       bubble_ex,
    output logic                       flush_fd
);
    localparam int NUM_OPS = 2;

    prod_t   ex_p, mem_p;
    reg_id_t ex_src [NUM_OPS];
    reg_id_t id_src [NUM_OPS];
    byp_e    ex_sel [NUM_OPS];
    byp_e    id_sel [NUM_OPS];
    logic    stall;

    assign ex_p      = '{dst: ex_rd,  wr: ex_we,  ld: ex_ld};
    assign mem_p     = '{dst: mem_rd, wr: mem_we, ld: mem_ld};
    assign ex_src[0] = ex_rs;
    assign ex_src[1] = ex_rt;
    assign id_src[0] = id_rs;
    assign id_src[1] = id_rt;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        hzd_ex_bypass u_exb (
            .src     (ex_src[i]),
            .mem_dst (mem_rd),
            .mem_wr  (mem_we),
            .wb_dst  (wb_rd),
            .wb_wr   (wb_we),
            .sel     (ex_sel[i])
        );
        hzd_id_bypass u_idb (
            .src   (id_src[i]),
            .mem_p (mem_p),
            .sel   (id_sel[i])
        );
    end

    hzd_stall u_stall (
        .id_rs  (id_rs),
        .id_rt  (id_rt),
        .id_beq (id_beq),
        .ex_p   (ex_p),
        .mem_p  (mem_p),
        .stall  (stall)
    );

    assign fwd_ex_a   = ex_sel[0];
    assign fwd_ex_b   = ex_sel[1];
    assign fwd_id_a   = id_sel[0];
    assign fwd_id_b   = id_sel[1];
    assign hold_fetch = stall;
    assign bubble_ex  = stall;
    // a stalled branch has not compared valid data yet, so it may not redirect
    assign flush_fd   = !stall && (id_jump || (id_beq && br_equal));
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk (
    input logic [4:0] id_rs,
    input logic [4:0] id_rt,
    input logic       id_beq,
    input logic       id_jump,
    input logic       br_equal,
    input logic [4:0] ex_rs,
    input logic [4:0] ex_rt,
    input logic [4:0] ex_rd,
    input logic       ex_we,
    input logic       ex_ld,
    input logic [4:0] mem_rd,
    input logic       mem_we,
    input logic       mem_ld,
    input logic [4:0] wb_rd,
    input logic       wb_we,
    input logic [1:0] fwd_ex_a,
    input logic [1:0] fwd_ex_b,
    input logic [1:0] fwd_id_a,
    input logic [1:0] fwd_id_b,
    input logic       hold_fetch,
    input logic       bubble_ex,
    input logic       flush_fd
);
    always_comb begin
        if (mem_we && mem_rd != 5'd0 && mem_rd == ex_rs)
            a_r1_mem_pick_a: assert (fwd_ex_a == 2'b10) else $error("R1 operand A");
        if (mem_we && mem_rd != 5'd0 && mem_rd == ex_rt)
            a_r1_mem_pick_b: assert (fwd_ex_b == 2'b10) else $error("R1 operand B");
        a_r2_code_legal: assert (fwd_ex_a != 2'b11 && fwd_ex_b != 2'b11) else $error("R2 code");
        if ((!mem_we || mem_rd == 5'd0) && (!wb_we || wb_rd == 5'd0))
            a_r4_zero_dst: assert (fwd_ex_a == 2'b00 && fwd_ex_b == 2'b00) else $error("R4");
        if (ex_ld && ex_we && ex_rd != 5'd0 && (ex_rd == id_rs || ex_rd == id_rt))
            a_r5_load_use: assert (hold_fetch && bubble_ex) else $error("R5");
        a_r8_no_wb_path: assert (!fwd_id_a[0] && !fwd_id_b[0]) else $error("R8 wb path");
        if (mem_ld)
            a_r8_no_load_byp: assert (fwd_id_a == 2'b00 && fwd_id_b == 2'b00) else $error("R8 load");
        if (flush_fd)
            a_r9_flush_cause: assert (id_jump || (id_beq && br_equal)) else $error("R9");
        a_r10_stall_wins: assert (!(hold_fetch && flush_fd)) else $error("R10");
    end
endmodule

bind hzd_unit hzd_unit_chk u_chk (
    .id_rs(id_rs), .id_rt(id_rt), .id_beq(id_beq), .id_jump(id_jump), .br_equal(br_equal),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_ld(mem_ld), .wb_rd(wb_rd), .wb_we(wb_we),
    .fwd_ex_a(fwd_ex_a), .fwd_ex_b(fwd_ex_b), .fwd_id_a(fwd_id_a), .fwd_id_b(fwd_id_b),
    .hold_fetch(hold_fetch), .bubble_ex(bubble_ex), .flush_fd(flush_fd)
);

// File: tb/hzd_unit_bench.sv
`timescale 1ns/1ps
module hzd_unit_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [4:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
    logic id_beq, id_jump, br_equal, ex_we, ex_ld, mem_we, mem_ld, wb_we;
    logic [1:0] fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b;
    logic hold_fetch, bubble_ex, flush_fd;

    int total = 0;
    int bad = 0;
    bit done = 0;

    hzd_unit u_hzd_unit (.*);

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_all();
        {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd} = '0;
        {id_beq, id_jump, br_equal, ex_we, ex_ld, mem_we, mem_ld, wb_we} = '0;
    endtask

    function automatic bit hit(int src, int dst, bit we);
        return we && dst != 0 && dst == src;
    endfunction

    function automatic int m_ex(int src);
        if (hit(src, mem_rd, mem_we)) return 2;
        if (hit(src, wb_rd, wb_we)) return 1;
        return 0;
    endfunction

    function automatic int m_id(int src);
        return (!mem_ld && hit(src, mem_rd, mem_we)) ? 2 : 0;
    endfunction

    function automatic bit m_stall();
        bit exd, memd;
        exd  = hit(id_rs, ex_rd, ex_we) || hit(id_rt, ex_rd, ex_we);
        memd = hit(id_rs, mem_rd, mem_we) || hit(id_rt, mem_rd, mem_we);
        return (ex_ld && exd) || (id_beq && exd) || (id_beq && mem_ld && memd);
    endfunction

    // full reference comparison, once per cycle, mid-cycle
    task automatic compare_all(string tag);
        bit s;
        s = m_stall();
        chk({tag, " fwd_ex_a"}, fwd_ex_a, m_ex(ex_rs));
        chk({tag, " fwd_ex_b"}, fwd_ex_b, m_ex(ex_rt));
        chk({tag, " fwd_id_a"}, fwd_id_a, m_id(id_rs));
        chk({tag, " fwd_id_b"}, fwd_id_b, m_id(id_rt));
        chk({tag, " hold"}, hold_fetch, s);
        chk({tag, " bubble"}, bubble_ex, s);
        chk({tag, " flush"}, flush_fd, !s && (id_jump || (id_beq && br_equal)));
    endtask

    task automatic settle();
        #5;
    endtask

    initial begin
        clear_all();
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(posedge clk); #2; settle();
        // reset / idle state
        chk("R11 idle hold", hold_fetch, 0);
        chk("R11 idle flush", flush_fd, 0);
        chk("R2 idle sel", fwd_ex_a, 0);

        // R1
        @(posedge clk); #2; clear_all();
        ex_rs = 5'd3; mem_rd = 5'd3; mem_we = 1; settle();
        chk("R1 ex a from mem", fwd_ex_a, 2); chk("R2 ex b rf", fwd_ex_b, 0);

        // R2
        @(posedge clk); #2; clear_all();
        ex_rt = 5'd7; wb_rd = 5'd7; wb_we = 1; settle();
        chk("R2 ex b from wb", fwd_ex_b, 1);

        // R3 priority
        @(posedge clk); #2; clear_all();
        ex_rs = 5'd9; mem_rd = 5'd9; mem_we = 1; wb_rd = 5'd9; wb_we = 1; settle();
        chk("R3 priority", fwd_ex_a, 2);

        // R4 reg 0 and write clear
        @(posedge clk); #2; clear_all();
        ex_rs = 5'd0; mem_rd = 5'd0; mem_we = 1; wb_rd = 5'd0; wb_we = 1;
        ex_rd = 5'd0; ex_we = 1; ex_ld = 1; id_beq = 1; settle();
        chk("R4 zero fwd", fwd_ex_a, 0); chk("R4 zero stall", hold_fetch, 0);
        @(posedge clk); #2; clear_all();
        ex_rt = 5'd4; mem_rd = 5'd4; mem_we = 0; ex_rd = 5'd2; ex_ld = 1; ex_we = 0; id_rs = 5'd2; settle();
        chk("R4 we clear fwd", fwd_ex_b, 0); chk("R4 we clear stall", hold_fetch, 0);

        // R5 load-use on rt
        @(posedge clk); #2; clear_all();
        ex_rd = 5'd5; ex_we = 1; ex_ld = 1; id_rt = 5'd5; settle();
        chk("R5 hold", hold_fetch, 1); chk("R5 bubble", bubble_ex, 1);

        // R6 branch on ALU in execute
        @(posedge clk); #2; clear_all();
        id_beq = 1; br_equal = 1; id_rs = 5'd6; ex_rd = 5'd6; ex_we = 1; settle();
        chk("R6 stall", hold_fetch, 1);
        chk("R10 no flush when stalled", flush_fd, 0);
        // same ALU now in memory: bypass into decode, compare valid, flush
        @(posedge clk); #2; clear_all();
        id_beq = 1; br_equal = 1; id_rs = 5'd6; mem_rd = 5'd6; mem_we = 1; settle();
        chk("R8 id bypass", fwd_id_a, 2); chk("R6 released", hold_fetch, 0);
        chk("R9 taken flush", flush_fd, 1);

        // R7 load -> branch over three cycles
        @(posedge clk); #2; clear_all();
        id_beq = 1; id_rt = 5'd8; ex_rd = 5'd8; ex_we = 1; ex_ld = 1; settle();
        chk("R7 cycle1 stall", hold_fetch, 1);
        @(posedge clk); #2; clear_all();
        id_beq = 1; id_rt = 5'd8; mem_rd = 5'd8; mem_we = 1; mem_ld = 1; settle();
        chk("R7 cycle2 stall", hold_fetch, 1); chk("R8 no load byp", fwd_id_b, 0);
        @(posedge clk); #2; clear_all();
        id_beq = 1; id_rt = 5'd8; wb_rd = 5'd8; wb_we = 1; settle();
        chk("R7 cycle3 free", hold_fetch, 0); chk("R8 no wb path", fwd_id_b, 0);
        chk("R11 not taken no flush", flush_fd, 0);

        // R9 jump, R10 jump behind load-use
        @(posedge clk); #2; clear_all(); id_jump = 1; settle();
        chk("R9 jump flush", flush_fd, 1);
        @(posedge clk); #2; clear_all();
        id_jump = 1; id_rs = 5'd1; ex_rd = 5'd1; ex_we = 1; ex_ld = 1; settle();
        chk("R10 jump stalled", flush_fd, 0); chk("R5 stall w jump", hold_fetch, 1);

        // random sweep against the reference model
        for (int n = 0; n < 2000; n++) begin
            @(posedge clk); #2;
            id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
            ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3));
            ex_rd = 5'($urandom_range(0, 3)); mem_rd = 5'($urandom_range(0, 3));
            wb_rd = 5'($urandom_range(0, 3));
            {id_beq, id_jump, br_equal, ex_we, ex_ld, mem_we, mem_ld, wb_we} = 8'($urandom);
            settle();
            compare_all("R1-model");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule